// File: doc/BRIEF.md
# Two-Bit Slice Carry-Chain Adder/Subtractor

This block is a parameterisable add/subtract unit whose datapath is divided into cells of two bit positions each. Every cell produces both of its sum bits and the carry it hands to the neighbouring cell. Cells are joined by a fixed carry chain that has no configurable routing. A two-bit mode input selects one of four operations: add, subtract, increment or decrement. Increment and decrement reuse the same chain with a constant second operand.

The carry into the most significant bit comes from the last cell's internal carry. A separate top stage takes that carry, recomputes the final carry-out from it, and forms the signed overflow flag as the XOR of the two. A build-time parameter numbers the cells from the least significant pair upward or from the most significant pair downward. Either numbering gives the same results at the ports. The block is purely combinational.

Top module: `slice_chain_adder`

## Requirements
- R1: With op_mode = 2'b00 (add), {carry_out, result} equals op_a + op_b + carry_in, taken to W+1 bits.
- R2: With op_mode = 2'b01 (subtract), result equals op_a - op_b modulo 2^W and carry_in has no effect. carry_out is 1 exactly when op_a >= op_b as unsigned values, meaning no borrow.
- R3: With op_mode = 2'b10 (increment), result equals op_a + 1 modulo 2^W, and carry_out is 1 only when op_a is all ones. op_b and carry_in have no effect.
- R4: With op_mode = 2'b11 (decrement), result equals op_a - 1 modulo 2^W, and carry_out is 0 only when op_a is zero. op_b and carry_in have no effect.
- R5: ovf is 1 exactly when the operation overflows as two's-complement arithmetic. It equals the XOR of the carry into bit W-1 and the carry out of bit W-1.
- R6: The carry-out recomputed by the top stage always matches the carry leaving the end of the two-bit cell chain.
- R7: W must be even and is built from W/2 cells. A W = 4 instance with cells numbered downward gives the results required by R1 to R5 for every input combination.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W | First operand |
| op_b | input | W | Second operand; used only in add and subtract |
| carry_in | input | 1 | Carry into bit 0; used only in add |
| op_mode | input | 2 | 00 add, 01 subtract, 10 increment, 11 decrement |
| result | output | W | Sum or difference |
| carry_out | output | 1 | Carry out of bit W-1 |
| ovf | output | 1 | Signed overflow |

## Verification
The hardest cases to reach are those where a carry must ripple through every cell. This happens for all-ones plus one, zero minus one, and add with a carry-in into a long run of ones. The same cases are needed where the carry into the top bit and the carry out of it disagree. Random operands almost never produce these patterns, so the stimulus names them directly at the signed and unsigned extremes in every mode. It also sweeps the 4-bit, downward-numbered instance exhaustively, which covers every ripple length and both overflow polarities.

// File: rtl/slice_chain_adder.sv
module slice_chain_adder #(
  parameter int W        = 8,
  parameter bit CARRY_UP = 1'b1
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         carry_in,
  input  logic [1:0]   op_mode,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         ovf
);
  localparam int NC = W / 2;

  initial begin
    if (W < 2 || (W % 2) != 0) $error("slice_chain_adder: W must be even and at least 2");
  end

  logic [W-1:0] b_eff;
  logic         c_first;
  logic [NC:0]  chain;
  logic [NC-1:0] mid;
  logic         chain_last;
  logic         c_top_in;

  always_comb begin
    unique case (op_mode)
      2'b00: begin b_eff = op_b;                   c_first = carry_in; end
      2'b01: begin b_eff = ~op_b;                  c_first = 1'b1;     end
      2'b10: begin b_eff = {{(W-1){1'b0}}, 1'b1};  c_first = 1'b0;     end
      default: begin b_eff = '1;                   c_first = 1'b0;     end
    endcase
  end

  generate
    if (CARRY_UP) begin : g_up
      assign chain[0]   = c_first;
      assign chain_last = chain[NC];
    end else begin : g_down
      assign chain[NC]  = c_first;
      assign chain_last = chain[0];
    end

    for (genvar p = 0; p < NC; p++) begin : g_cell
      localparam int KIN  = CARRY_UP ? p     : NC - p;
      localparam int KOUT = CARRY_UP ? p + 1 : NC - 1 - p;
      logic a0, a1, b0, b1, ci;
      assign a0 = op_a[2*p];
      assign a1 = op_a[2*p+1];
      assign b0 = b_eff[2*p];
      assign b1 = b_eff[2*p+1];
      assign ci = chain[KIN];
      assign result[2*p]   = a0 ^ b0 ^ ci;
      assign mid[p]        = (a0 & b0) | ((a0 ^ b0) & ci);
      assign result[2*p+1] = a1 ^ b1 ^ mid[p];
      assign chain[KOUT]   = (a1 & b1) | ((a1 ^ b1) & mid[p]);
    end
  endgenerate

  assign c_top_in  = mid[NC-1];
  assign carry_out = (op_a[W-1] & b_eff[W-1]) | ((op_a[W-1] ^ b_eff[W-1]) & c_top_in);
  assign ovf       = c_top_in ^ carry_out;
endmodule

// File: rtl/slice_chain_adder_chk.sv
module slice_chain_adder_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         carry_in,
  input logic [1:0]   op_mode,
  input logic [W-1:0] result,
  input logic         carry_out,
  input logic         ovf,
  input logic         chain_last
);
  localparam logic [W-1:0] ONES = '1;
  localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINN = {1'b1, {(W-1){1'b0}}};

  always_comb begin
    if (op_mode == 2'b00 && !carry_in && op_b == '0)
      assert_add_zero_R1: assert (result == op_a && !carry_out && !ovf)
        else $error("add of zero changed operand");
    if (op_mode == 2'b01 && op_a == op_b)
      assert_sub_self_R2: assert (result == '0 && carry_out && !ovf)
        else $error("self subtract not zero");
    if (op_mode == 2'b10 && op_a == ONES)
      assert_inc_wrap_R3: assert (result == '0 && carry_out)
        else $error("increment wrap wrong");
    if (op_mode == 2'b11 && op_a == '0)
      assert_dec_wrap_R4: assert (result == ONES && !carry_out)
        else $error("decrement wrap wrong");
    if (op_mode == 2'b00 && ovf)
      assert_add_ovf_sign_R5: assert (op_a[W-1] == op_b[W-1] && result[W-1] != op_a[W-1])
        else $error("add overflow with mixed signs");
    if (op_mode == 2'b10)
      assert_inc_ovf_R5: assert (ovf == (op_a == MAXP))
        else $error("increment overflow wrong");
    if (op_mode == 2'b11)
      assert_dec_ovf_R5: assert (ovf == (op_a == MINN))
        else $error("decrement overflow wrong");
    assert_chain_match_R6: assert (chain_last == carry_out)
      else $error("recomputed carry differs from chain end");
  end
endmodule

bind slice_chain_adder slice_chain_adder_chk #(.W(W)) u_chk (.*);

// File: tb/test_slice_chain_adder.sv
module test_slice_chain_adder;
  typedef struct {
    bit         unit;
    logic [7:0] a, b;
    logic       cin;
    logic [1:0] mode;
    logic [7:0] exp_sum;
    logic       exp_c, exp_v;
    string      tag;
  } item_t;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [7:0] a8 = '0, b8 = '0, r8;
  logic       ci8 = 1'b0, c8, v8;
  logic [1:0] m8 = 2'b00;
  logic [3:0] a4 = '0, b4 = '0, r4;
  logic       ci4 = 1'b0, c4, v4;
  logic [1:0] m4 = 2'b00;

  slice_chain_adder #(.W(8), .CARRY_UP(1'b1)) i_slice_chain_adder (
    .op_a(a8), .op_b(b8), .carry_in(ci8), .op_mode(m8),
    .result(r8), .carry_out(c8), .ovf(v8));

  slice_chain_adder #(.W(4), .CARRY_UP(1'b0)) i_slice_chain_adder_w4 (
    .op_a(a4), .op_b(b4), .carry_in(ci4), .op_mode(m4),
    .result(r4), .carry_out(c4), .ovf(v4));

  item_t q[$];
  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  function automatic void model(input int w, input int a, input int b, input bit cin,
                                input logic [1:0] mode, output logic [7:0] s,
                                output logic c, output logic v);
    int mask = (1 << w) - 1;
    int bb, cc, full, sa, sb, ss;
    case (mode)
      2'b00: begin bb = b;           cc = int'(cin); end
      2'b01: begin bb = (~b) & mask; cc = 1;         end
      2'b10: begin bb = 1;           cc = 0;         end
      default: begin bb = mask;      cc = 0;         end
    endcase
    full = a + bb + cc;
    s  = 8'(full & mask);
    c  = full[w];
    sa = (a >> (w-1)) & 1;
    sb = (bb >> (w-1)) & 1;
    ss = (full >> (w-1)) & 1;
    v  = (sa == sb) && (ss != sa);
  endfunction

  task automatic apply(input bit unit, input logic [7:0] a, input logic [7:0] b,
                       input logic cin, input logic [1:0] mode, input string tag);
    item_t it;
    @(negedge clk);
    it.unit = unit; it.a = a; it.b = b; it.cin = cin; it.mode = mode; it.tag = tag;
    model(unit ? 4 : 8, int'(a), int'(b), cin, mode, it.exp_sum, it.exp_c, it.exp_v);
    if (unit) begin a4 = a[3:0]; b4 = b[3:0]; ci4 = cin; m4 = mode; end
    else      begin a8 = a;      b8 = b;      ci8 = cin; m8 = mode; end
    q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    logic [7:0] gs;
    logic gc, gv;
    forever begin
      @(posedge clk);
      if (q.size() > 0) begin
        it = q.pop_front();
        #1;
        if (it.unit) begin gs = {4'b0, r4}; gc = c4; gv = v4; end
        else         begin gs = r8;         gc = c8; gv = v8; end
        n_checks++;
        if (gs !== it.exp_sum || gc !== it.exp_c || gv !== it.exp_v) begin
          n_fail++;
          $display("FAIL %s: w%0d mode=%b a=%h b=%h cin=%b got sum=%h c=%b v=%b exp sum=%h c=%b v=%b",
                   it.tag, it.unit ? 4 : 8, it.mode, it.a, it.b, it.cin,
                   gs, gc, gv, it.exp_sum, it.exp_c, it.exp_v);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : driver
    apply(0, 8'h00, 8'h00, 1'b0, 2'b00, "R1 idle zero");
    apply(0, 8'h3c, 8'h41, 1'b0, 2'b00, "R1 add");
    apply(0, 8'hff, 8'h00, 1'b1, 2'b00, "R1 full ripple carry_in");
    apply(0, 8'hff, 8'hff, 1'b1, 2'b00, "R1 max add");
    apply(0, 8'h55, 8'haa, 1'b1, 2'b00, "R1 alternating ripple");
    apply(0, 8'h10, 8'h20, 1'b0, 2'b01, "R2 sub borrow");
    apply(0, 8'h20, 8'h10, 1'b1, 2'b01, "R2 sub carry_in ignored");
    apply(0, 8'h20, 8'h10, 1'b0, 2'b01, "R2 sub no borrow");
    apply(0, 8'h00, 8'h01, 1'b0, 2'b01, "R2 zero minus one");
    apply(0, 8'hff, 8'h3a, 1'b1, 2'b10, "R3 inc wrap b ignored");
    apply(0, 8'h41, 8'hc3, 1'b1, 2'b10, "R3 inc b and carry_in ignored");
    apply(0, 8'h00, 8'h77, 1'b1, 2'b11, "R4 dec of zero");
    apply(0, 8'h80, 8'h12, 1'b0, 2'b11, "R4 dec min");
    apply(0, 8'h7f, 8'h01, 1'b0, 2'b00, "R5 add positive overflow");
    apply(0, 8'h80, 8'h80, 1'b0, 2'b00, "R5 add negative overflow");
    apply(0, 8'h80, 8'h01, 1'b0, 2'b01, "R5 sub overflow");
    apply(0, 8'h7f, 8'hff, 1'b0, 2'b01, "R5 sub overflow pos");
    apply(0, 8'h7f, 8'h00, 1'b0, 2'b10, "R5 inc overflow");
    for (int i = 0; i < 3000; i++)
      apply(0, 8'($urandom), 8'($urandom), 1'($urandom), 2'($urandom), "R6 random");
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          for (int c = 0; c < 2; c++)
            apply(1, 8'(a), 8'(b), 1'(c), 2'(m), "R7 w4 down exhaustive");
    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule